// File: doc/BRIEF.md
# Serial Write Port with Daisy-Chain Pass-Through

This block is the serial front end of a multi-channel converter's register interface. A host frames each transfer by pulling the active-low sync line low. It then clocks bits in on a serial data line, most significant bit first, and releases sync to close the frame. The block samples a data bit on every falling serial-clock edge inside a frame. When the frame closes with a valid bit count, it hands the assembled 24-bit word to the register-write logic downstream. The word carries an 8-bit address in bits 23:16, a 2-bit register selector in bits 15:14 and a 14-bit data payload in bits 13:0, with bit 13 as the payload MSB.

A level-sensitive mode input selects daisy-chain operation when the serial-select input is also high. In that mode the serial output drives, on each rising serial-clock edge, the bit that entered the shift register 23 captures earlier. A downstream device therefore captures it at its next falling edge, 24 clocks after it arrived here. The word kept is whatever occupies the last 24 bits when sync rises. All serial inputs are asynchronous to `clk` and are synchronised inside the block. Each high and each low phase of the serial clock, and each setup and hold of data around a falling edge, must last at least two `clk` periods.

The downstream side is a valid/ready stream. Once `m_valid` rises, the word and `m_valid` hold until a cycle with `m_ready` high. A word completed while the previous one is still unaccepted is discarded. A word completed in the same cycle that the pending one is accepted replaces it.

Top module: `serial_write_port`

## Requirements
- R1: After reset, and after a reset applied in the middle of a frame, `m_valid` is 0 and `sdo` is 0.
- R2: With `ser_sel`=1 and `dc_en`=0, a frame of exactly 24 falling edges raises `m_valid` after sync rises. The fields are `m_addr` = bits 23:16, `m_sel` = bits 15:14 and `m_data` = bits 13:0, where bit 23 is the first bit sent.
- R3: With `ser_sel`=1 and `dc_en`=0, a frame of 23 or of 25 falling edges produces no word.
- R4: With `ser_sel`=0, frames produce no word and `sdo` stays 0, whatever `dc_en` is.
- R5: With `ser_sel`=1 and `dc_en`=1, a frame of 24 or more falling edges delivers the last 24 bits received.
- R6: In daisy-chain mode, the rising edge after the k-th falling edge of a frame drives bit k-23 of the frame (counting from 1) on `sdo`, or 0 while k<24. Outside daisy-chain mode `sdo` is 0.
- R7: `sdo` changes only on a rising serial-clock edge while daisy-chain mode holds. Between a falling edge and the next rising edge it keeps its value.
- R8: While `m_valid`=1 and `m_ready`=0, the word is held stable. A frame finishing in that time is discarded.
- R9: With `ser_sel`=1 and `dc_en`=1, a frame of fewer than 24 falling edges produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel | input | 1 | 1 selects the serial port; 0 leaves it idle |
| dc_en | input | 1 | Level-sensitive daisy-chain enable |
| sync_n | input | 1 | Active-low frame sync |
| sclk | input | 1 | Serial clock, idles high |
| sdin | input | 1 | Serial data in, sampled on falling edges |
| sdo | output | 1 | Serial data out, launched on rising edges |
| m_valid | output | 1 | Word available |
| m_ready | input | 1 | Downstream accepts the word |
| m_addr | output | 8 | Address field |
| m_sel | output | 2 | Register selector field |
| m_data | output | 14 | Data payload |

## Verification
The assertions check four things on every cycle: that a held word stays stable under back-pressure, that `m_valid` rises only after a frame end, that no word appears while the serial port is deselected, and that `sdo` is 0 outside daisy-chain mode and moves only on a rising serial edge. Field placement, the rejection of wrong bit counts, the last-24-bit selection in daisy-chain mode and the exact 24-clock delay of the data on `sdo` are shown only by the bench's frame scenarios. Those scenarios compare full words and per-edge output samples against values derived from the sent bits.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    SP_OFF    = 2'd0,
    SP_FRAMED = 2'd1,
    SP_CHAIN  = 2'd2
  } sp_mode_e;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g] <= RST_VAL;
      else if (g == 0) stage[g] <= d;
      else stage[g] <= stage[(g == 0) ? 0 : g-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sp_edge.sv
module sp_edge #(
  parameter int              WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= cur;
  end

  assign rise = cur & ~prev;
  assign fall = ~cur & prev;
endmodule

// File: rtl/sp_shifter.sv
module sp_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bit_fall,
  input  logic              din,
  output logic [WORD_W-1:0] sreg,
  output logic              cnt_exact,
  output logic              cnt_enough
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(WORD_W + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (start) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (bit_fall) begin
      sreg <= {sreg[WORD_W-2:0], din};
      if (cnt != SAT) cnt <= cnt + 1'b1;
    end
  end

  assign cnt_exact  = (cnt == FULL);
  assign cnt_enough = (cnt >= FULL);
endmodule

// File: rtl/sp_chain_out.sv
module sp_chain_out (
  input  logic clk,
  input  logic rst_n,
  input  logic daisy,
  input  logic bit_rise,
  input  logic msb,
  output logic sdo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sdo <= 1'b0;
    else if (!daisy)   sdo <= 1'b0;
    else if (bit_rise) sdo <= msb;
  end
endmodule

// File: rtl/sp_out_stage.sv
module sp_out_stage #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] word_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      word_out <= '0;
    end else if (load && (!valid || ready)) begin
      valid    <= 1'b1;
      word_out <= word_in;
    end else if (ready) begin
      valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_write_port.sv
module serial_write_port #(
  parameter int ADDR_W      = 8,
  parameter int SEL_W       = 2,
  parameter int DATA_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel,
  input  logic              dc_en,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic              sdo,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [ADDR_W-1:0] m_addr,
  output logic [SEL_W-1:0]  m_sel,
  output logic [DATA_W-1:0] m_data
);
  import sp_pkg::*;

  localparam int WORD_W = ADDR_W + SEL_W + DATA_W;

  logic [4:0] raw_in, syn_in;
  logic ser_q, dc_q, sync_q, sclk_q, sdin_q;
  logic [1:0] edge_rise, edge_fall;
  logic sync_rise, sync_fall, sclk_rise, sclk_fall;
  logic frame_start, frame_end, in_frame, bit_fall, bit_rise, daisy_q;
  logic cnt_exact, cnt_enough, word_ok;
  logic [WORD_W-1:0] sreg, word_q;
  sp_mode_e mode;

  assign raw_in = {ser_sel, dc_en, sync_n, sclk, sdin};

  sp_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b00110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign {ser_q, dc_q, sync_q, sclk_q, sdin_q} = syn_in;

  sp_edge #(.WIDTH(2), .RST_VAL(2'b11)) u_edge (
    .clk(clk), .rst_n(rst_n), .cur({sync_q, sclk_q}),
    .rise(edge_rise), .fall(edge_fall)
  );

  assign {sync_rise, sclk_rise} = edge_rise;
  assign {sync_fall, sclk_fall} = edge_fall;

  always_comb begin
    if (!ser_q)    mode = SP_OFF;
    else if (dc_q) mode = SP_CHAIN;
    else           mode = SP_FRAMED;
  end

  assign daisy_q     = (mode == SP_CHAIN);
  assign in_frame    = ser_q && !sync_q;
  assign frame_start = ser_q && sync_fall;
  assign frame_end   = ser_q && sync_rise;
  assign bit_fall    = in_frame && sclk_fall;
  assign bit_rise    = in_frame && sclk_rise;

  sp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(frame_start), .bit_fall(bit_fall),
    .din(sdin_q), .sreg(sreg), .cnt_exact(cnt_exact), .cnt_enough(cnt_enough)
  );

  always_comb begin
    unique case (mode)
      SP_FRAMED: word_ok = frame_end && cnt_exact;
      SP_CHAIN:  word_ok = frame_end && cnt_enough;
      default:   word_ok = 1'b0;
    endcase
  end

  sp_chain_out u_chain (
    .clk(clk), .rst_n(rst_n), .daisy(daisy_q), .bit_rise(bit_rise),
    .msb(sreg[WORD_W-1]), .sdo(sdo)
  );

  sp_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(word_ok), .word_in(sreg),
    .ready(m_ready), .valid(m_valid), .word_out(word_q)
  );

  assign m_addr = word_q[WORD_W-1 -: ADDR_W];
  assign m_sel  = word_q[DATA_W +: SEL_W];
  assign m_data = word_q[DATA_W-1:0];
endmodule

// File: rtl/sp_port_checker.sv
module sp_port_checker #(
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 2,
  parameter int DATA_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_valid,
  input logic              m_ready,
  input logic [ADDR_W-1:0] m_addr,
  input logic [SEL_W-1:0]  m_sel,
  input logic [DATA_W-1:0] m_data,
  input logic              sdo,
  input logic              frame_end,
  input logic              ser_q,
  input logic              daisy_q,
  input logic              sclk_rise
);
  // R8: a held word does not move while back-pressured
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable({m_addr, m_sel, m_data})));

  // R2: a new word only follows a frame end
  p_word_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(frame_end));

  // R4: deselected port never raises a word
  p_port_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_q |=> !$rose(m_valid));

  // R6: output quiet outside daisy-chain mode
  p_sdo_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !daisy_q |=> !sdo);

  // R7: output moves only on a rising serial edge
  p_sdo_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (daisy_q && !sclk_rise) |=> $stable(sdo));
endmodule

bind serial_write_port sp_port_checker #(
  .ADDR_W(ADDR_W), .SEL_W(SEL_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
  .m_addr(m_addr), .m_sel(m_sel), .m_data(m_data), .sdo(sdo),
  .frame_end(frame_end), .ser_q(ser_q), .daisy_q(daisy_q), .sclk_rise(sclk_rise)
);

// File: tb/serial_write_port_test.sv
module serial_write_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_sel = 1'b0, dc_en = 1'b0, sync_n = 1'b1, sclk = 1'b1, sdin = 1'b0;
  logic m_ready = 1'b0;
  logic sdo, m_valid;
  logic [7:0]  m_addr;
  logic [1:0]  m_sel;
  logic [13:0] m_data;

  int checks = 0;
  int fails  = 0;
  logic pre_s  [49];
  logic post_s [49];

  always #4 clk = ~clk;

  serial_write_port uut (
    .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .dc_en(dc_en),
    .sync_n(sync_n), .sclk(sclk), .sdin(sdin), .sdo(sdo),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr),
    .m_sel(m_sel), .m_data(m_data)
  );

  // {ser_sel, dc_en, bit count, bits (first sent = bit count-1)}
  localparam logic [56:0] VEC [10] = '{
    {1'b1, 1'b0, 7'd24, 48'h0000_00A5_9C3E},
    {1'b1, 1'b0, 7'd24, 48'h0000_000F_7FFF},
    {1'b1, 1'b0, 7'd23, 48'h0000_0012_3456},
    {1'b1, 1'b0, 7'd25, 48'h0000_01AB_CDEF},
    {1'b0, 1'b0, 7'd24, 48'h0000_00A5_A5A5},
    {1'b1, 1'b1, 7'd48, 48'h1234_56C0_FFEE},
    {1'b1, 1'b1, 7'd20, 48'h0000_000F_0F0F},
    {1'b0, 1'b1, 7'd48, 48'hFFFF_FFFF_FFFF},
    {1'b1, 1'b1, 7'd24, 48'h0000_0033_8001},
    {1'b1, 1'b1, 7'd30, 48'h0000_3FDE_AD42}
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic send(input int n, input logic [47:0] bits);
    sync_n = 1'b0;
    wait_n(4);
    for (int k = 1; k <= n; k++) begin
      sdin = bits[n-k];
      wait_n(2);
      sclk = 1'b0;
      wait_n(4);
      pre_s[k] = sdo;
      sclk = 1'b1;
      wait_n(6);
      post_s[k] = sdo;
    end
    wait_n(4);
    sync_n = 1'b1;
    wait_n(10);
  endtask

  task automatic ack();
    m_ready = 1'b1;
    wait_n(1);
    m_ready = 1'b0;
    wait_n(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog: actual %0h expected %0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    wait_n(3);
    // R1: reset state
    chk(m_valid == 1'b0, "R1", "m_valid after reset", 32'(m_valid), 0);
    chk(sdo == 1'b0, "R1", "sdo after reset", 32'(sdo), 0);
    rst_n = 1'b1;
    wait_n(4);

    for (int v = 0; v < 10; v++) begin
      logic s, d, expv, sdo_ok, hold_ok;
      int n;
      logic [47:0] b;
      logic [23:0] w;
      string tag;
      {s, d} = VEC[v][56:55];
      n = int'(VEC[v][54:48]);
      b = VEC[v][47:0];
      ser_sel = s;
      dc_en = d;
      wait_n(6);
      send(n, b);
      expv = s && ((!d && n == 24) || (d && n >= 24));
      w = b[23:0];
      if (!s) tag = "R4";
      else if (!d) tag = (n == 24) ? "R2" : "R3";
      else tag = (n >= 24) ? "R5" : "R9";
      chk(m_valid == expv, tag, "m_valid after frame", 32'(m_valid), 32'(expv));
      if (expv) begin
        chk({m_addr, m_sel, m_data} == w, tag, "word fields",
            32'({m_addr, m_sel, m_data}), 32'(w));
        chk(m_addr == w[23:16] && m_sel == w[15:14] && m_data == w[13:0],
            "R2", "field split", 32'(m_data), 32'(w[13:0]));
        ack();
        chk(m_valid == 1'b0, "R8", "m_valid after accept", 32'(m_valid), 0);
      end
      // R6: per-edge output samples
      sdo_ok = 1'b1;
      for (int k = 1; k <= n; k++) begin
        logic e;
        e = (s && d && k >= 24) ? b[n-(k-23)] : 1'b0;
        if (post_s[k] !== e) sdo_ok = 1'b0;
      end
      chk(sdo_ok, (s ? "R6" : "R4"), "sdo sequence", 32'(v), 32'(v));
      // R7: output unchanged between a falling edge and the next rising edge
      hold_ok = 1'b1;
      for (int k = 2; k <= n; k++)
        if (pre_s[k] !== post_s[k-1]) hold_ok = 1'b0;
      chk(hold_ok, "R7", "sdo held across falling edge", 32'(v), 32'(v));
    end

    // R8: back-pressure holds the first word and drops the second
    ser_sel = 1'b1;
    dc_en = 1'b0;
    wait_n(6);
    send(24, 48'h0000_0012_3456);
    chk(m_valid == 1'b1, "R8", "first word pending", 32'(m_valid), 1);
    send(24, 48'h0000_0065_4321);
    chk({m_addr, m_sel, m_data} == 24'h123456, "R8", "held word",
        32'({m_addr, m_sel, m_data}), 32'h123456);
    ack();
    chk(m_valid == 1'b0, "R8", "second word dropped", 32'(m_valid), 0);

    // R1: reset in the middle of a daisy-chain frame
    dc_en = 1'b1;
    wait_n(6);
    sync_n = 1'b0;
    wait_n(4);
    for (int k = 0; k < 30; k++) begin
      sdin = 1'b1;
      wait_n(2);
      sclk = 1'b0;
      wait_n(4);
      sclk = 1'b1;
      wait_n(6);
    end
    chk(sdo == 1'b1, "R6", "sdo driven before reset", 32'(sdo), 1);
    rst_n = 1'b0;
    wait_n(2);
    chk(sdo == 1'b0, "R1", "sdo after mid-frame reset", 32'(sdo), 0);
    chk(m_valid == 1'b0, "R1", "m_valid after mid-frame reset", 32'(m_valid), 0);
    sync_n = 1'b1;
    rst_n = 1'b1;
    wait_n(10);
    chk(m_valid == 1'b0, "R1", "no word after aborted frame", 32'(m_valid), 0);

    summary();
    $finish;
  end
endmodule